// File: doc/BRIEF.md
# Table-driven wall-following robot controller

This block steers a two-antenna maze robot along a wall kept on its right side. Each antenna reports 1 while it is in contact. Each cycle the block chooses among three actuator commands: a forward step, a small counterclockwise turn and a small clockwise turn. The policy is a four-state machine. Its next-state and command logic is a single lookup table of 16 five-bit words. The table address is the current state and the two sensor bits. A five-bit register captures the selected word.

Each word holds the next state and the commands that belong to that next state. The registered commands are therefore a Moore output of the registered state. An `advance` input lets the surrounding system decide which clocks count as a control step. The states are: searching (moving ahead until something is hit), rotating away from an obstacle, curving right to find the wall, and edging left along it.

Top module: `wallbot_lut_fsm`

## Requirements
- R1: A synchronous active-high `rst` loads state 00 and drives `fwd`, `turn_left` and `turn_right` to 0 on the next clock edge.
- R2: After every update, the outputs depend on the new state only:
  - 00 (searching) gives `fwd`.
  - 01 (rotating) gives `turn_left`.
  - 10 (curving) gives `fwd` and `turn_right`.
  - 11 (edging) gives `fwd` and `turn_left`.
- R3: From state 00, contact on either antenna moves to 01. No contact keeps state 00.
- R4: From state 01, contact on either antenna keeps state 01. No contact moves to 10.
- R5: From state 10, the left antenna moves to 01 whatever the right antenna reads. The right antenna alone moves to 11. No contact keeps state 10.
- R6: From state 11, the left antenna moves to 01 whatever the right antenna reads. The right antenna alone keeps state 11. No contact moves to 10.
- R7: On a clock edge with `advance` low and `rst` low, state and outputs keep their values.
- R8: State and outputs change only at a clock edge. A change on the sensor inputs between edges has no effect on them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| advance | input | 1 | Take one control step on this edge |
| sense_left | input | 1 | Left antenna contact |
| sense_right | input | 1 | Right antenna contact |
| state | output | 2 | Registered state code |
| fwd | output | 1 | Forward step command |
| turn_left | output | 1 | Counterclockwise turn command |
| turn_right | output | 1 | Clockwise turn command |

## Verification
The bench builds the block with its default widths: a two-bit state, two sensors and three commands. With these widths all 16 table words can be reached. The bench drives the controller into each of the four states along a known sensor path and then applies each sensor pair, so every word is checked for both its next state and its commands. Directed cases then cover the left-antenna priority, holding with `advance` low, sensor changes between edges, and a reset in the middle of a run.

// File: rtl/wallbot_lut_fsm.sv
module wallbot_lut_fsm #(
  parameter int STATE_W = 2,
  parameter int SENSE_W = 2,
  parameter int ACT_W   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               advance,
  input  logic               sense_left,
  input  logic               sense_right,
  output logic [STATE_W-1:0] state,
  output logic               fwd,
  output logic               turn_left,
  output logic               turn_right
);
  localparam int ADDR_W = STATE_W + SENSE_W;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int WORD_W = STATE_W + ACT_W;

  localparam logic [STATE_W-1:0] S_SEEK  = STATE_W'(0);
  localparam logic [STATE_W-1:0] S_SPIN  = STATE_W'(1);
  localparam logic [STATE_W-1:0] S_CURVE = STATE_W'(2);
  localparam logic [STATE_W-1:0] S_EDGE  = STATE_W'(3);

  function automatic logic [STATE_W-1:0] next_of(logic [STATE_W-1:0] s, logic l, logic r);
    case (s)
      S_SEEK:  next_of = (l || r) ? S_SPIN : S_SEEK;
      S_SPIN:  next_of = (l || r) ? S_SPIN : S_CURVE;
      S_CURVE: next_of = l ? S_SPIN : (r ? S_EDGE : S_CURVE);
      default: next_of = l ? S_SPIN : (r ? S_EDGE : S_CURVE);
    endcase
  endfunction

  function automatic logic [ACT_W-1:0] acts_of(logic [STATE_W-1:0] s);
    case (s)
      S_SEEK:  acts_of = ACT_W'(3'b100);
      S_SPIN:  acts_of = ACT_W'(3'b010);
      S_CURVE: acts_of = ACT_W'(3'b101);
      default: acts_of = ACT_W'(3'b110);
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] word_at(int a);
    logic [ADDR_W-1:0] av;
    logic [STATE_W-1:0] ns;
    av = ADDR_W'(a);
    ns = next_of(av[ADDR_W-1:SENSE_W], av[SENSE_W-1], av[0]);
    word_at = {ns, acts_of(ns)};
  endfunction

  logic [WORD_W-1:0] lut [DEPTH];
  for (genvar i = 0; i < DEPTH; i++) begin : g_lut
    assign lut[i] = word_at(i);
  end

  logic [WORD_W-1:0] held;
  logic [ADDR_W-1:0] addr;

  assign addr = {held[WORD_W-1:ACT_W], sense_left, sense_right};
  assign {state, fwd, turn_left, turn_right} = held;

  always_ff @(posedge clk) begin
    if (rst)          held <= '0;
    else if (advance) held <= lut[addr];
  end

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (state == S_SEEK && !fwd && !turn_left && !turn_right));

  p_spin_cmd_r2: assert property (@(posedge clk) disable iff (rst)
    (state == S_SPIN) |-> (turn_left && !fwd && !turn_right));

  p_no_dual_turn_r2: assert property (@(posedge clk) disable iff (rst)
    !(turn_left && turn_right));

  p_seek_exit_r3: assert property (@(posedge clk) disable iff (rst)
    (advance && state == S_SEEK && (sense_left || sense_right)) |=> (state == S_SPIN));

  p_spin_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (advance && state == S_SPIN && !sense_left && !sense_right) |=> (state == S_CURVE));

  p_left_wins_r5: assert property (@(posedge clk) disable iff (rst)
    (advance && state == S_CURVE && sense_left) |=> (state == S_SPIN));

  p_edge_lost_r6: assert property (@(posedge clk) disable iff (rst)
    (advance && state == S_EDGE && !sense_left && !sense_right) |=> (state == S_CURVE));

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !advance |=> $stable({state, fwd, turn_left, turn_right}));
endmodule

// File: tb/wallbot_lut_fsm_tb.sv
module wallbot_lut_fsm_tb;
  logic clk = 0, rst = 1, advance = 0, sl = 0, sr = 0;
  logic [1:0] state;
  logic fwd, tl, tr;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  wallbot_lut_fsm u_dut (.clk(clk), .rst(rst), .advance(advance), .sense_left(sl),
    .sense_right(sr), .state(state), .fwd(fwd), .turn_left(tl), .turn_right(tr));

  // {state, L, R, next state, F, TL, TR}
  localparam logic [8:0] VEC [16] = '{
    9'b00_00_00_100, 9'b00_01_01_010, 9'b00_10_01_010, 9'b00_11_01_010,
    9'b01_00_10_101, 9'b01_01_01_010, 9'b01_10_01_010, 9'b01_11_01_010,
    9'b10_00_10_101, 9'b10_01_11_110, 9'b10_10_01_010, 9'b10_11_01_010,
    9'b11_00_10_101, 9'b11_01_11_110, 9'b11_10_01_010, 9'b11_11_01_010
  };

  task automatic check(string tag, logic [4:0] got, logic [4:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic step(logic a, logic l, logic r);
    @(negedge clk); advance = a; sl = l; sr = r;
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; advance = 0;
    @(posedge clk); #1;
    @(negedge clk); rst = 0;
  endtask

  task automatic go_to(logic [1:0] s);
    do_reset();
    if (s != 2'b00) step(1, 1, 0);
    if (s[1]) step(1, 0, 0);
    if (s == 2'b11) step(1, 0, 1);
  endtask

  function automatic string tag_of(logic [1:0] s);
    case (s)
      2'b00: return "R3";
      2'b01: return "R4";
      2'b10: return "R5";
      default: return "R6";
    endcase
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    check("R1 reset", {state, fwd, tl, tr}, 5'b00_000);

    foreach (VEC[i]) begin
      go_to(VEC[i][8:7]);
      check("R2 reach state", {3'b000, state}, {3'b000, VEC[i][8:7]});
      step(1, VEC[i][6], VEC[i][5]);
      check(tag_of(VEC[i][8:7]), {3'b000, state}, {3'b000, VEC[i][4:3]});
      check("R2 commands", {2'b00, fwd, tl, tr}, {2'b00, VEC[i][2:0]});
    end

    // R7: hold with advance low while sensors would cause a move
    go_to(2'b10);
    step(0, 1, 1);
    check("R7 hold", {state, fwd, tl, tr}, 5'b10_101);
    step(0, 0, 1);
    check("R7 hold again", {state, fwd, tl, tr}, 5'b10_101);

    // R8: sensor change between edges has no effect
    @(negedge clk); sl = 1; sr = 1; #2;
    check("R8 between edges", {state, fwd, tl, tr}, 5'b10_101);

    // R3: long run without contact stays searching with forward step
    do_reset();
    for (int k = 0; k < 5; k++) step(1, 0, 0);
    check("R3 stay searching", {state, fwd, tl, tr}, 5'b00_100);

    // R1: reset in the middle of a run
    go_to(2'b11);
    do_reset();
    check("R1 mid-run reset", {state, fwd, tl, tr}, 5'b00_000);

    // R6: edging holds while right antenna touches
    go_to(2'b11);
    step(1, 0, 1);
    step(1, 0, 1);
    check("R6 edge hold", {state, fwd, tl, tr}, 5'b11_110);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule